// File: doc/BRIEF.md
# SPI Mode Fault Detector

This block guards an SPI port against two devices driving the same lines. It compares the slave-select pin with the role the port has been given. When the two disagree, it sets a sticky fault flag. The pin is active low and arrives without any timing relation to the clock, so the block first resynchronizes it.

In the master role, any low level on the synchronized select is a fault. A master fault also tears the port down. In the cycle the flag sets, the block issues single-cycle requests that:

- clear the port enable,
- set the transmit-empty flag,
- reset the bit counter.

In that same cycle it withdraws the port's output enables, which returns the pins to general-purpose port control.

In the slave role, only a rising select during an active transfer is a fault, and the slave is not torn down.

Software clears the flag with a two-step handshake: first read the status register while the flag is set, then write the control register.

Top module: `spi_modefault_det`

## Requirements
- R1: `ss_n_i` passes through two synchronizer flops. A change on it can affect `fault_o` no earlier than the third rising clock edge after the change.
- R2: In the master role (`master_i`=1) with `spi_en_i`=1 and `fault_en_i`=1, a low synchronized select sets `fault_o` on the next edge.
- R3: In the slave role (`master_i`=0) with `spi_en_i`=1 and `fault_en_i`=1, `fault_o` sets only on a synchronized low-to-high select edge while `xfer_active_i`=1. A high select level alone does not set it, and neither does a rise while no transfer is active.
- R4: `fault_o` can only set while `fault_en_i`=1. Dropping `fault_en_i` leaves an already set flag unchanged.
- R5: A cycle with `stat_rd_i`=1 while `fault_o`=1 arms the clear. A later cycle with `ctrl_wr_i`=1 then drops `fault_o` on that edge. Any `ctrl_wr_i` disarms. A write that is not armed leaves the flag set.
- R6: If the fault condition is present in the cycle of an armed clearing write, `fault_o` stays 1.
- R7: `irq_o` is 1 exactly when `fault_o`=1 and `err_ie_i`=1.
- R8: A master fault drives `en_clr_o`, `tx_empty_set_o` and `cnt_rst_o` to 1 in the same cycle `fault_o` is set by it. These outputs stay 1 only while the master condition persists. A slave fault never drives them.
- R9: With `spi_en_i`=1 in the master role, `sck_oe_o`=`mosi_oe_o`=1 and `miso_oe_o`=0. In the slave role, `miso_oe_o`=1 and the other two are 0. With `spi_en_i`=0, or while `en_clr_o`=1, `sck_oe_o` and `mosi_oe_o` are 0.
- R10: During and after reset, `fault_o`, `irq_o` and the teardown outputs are 0, and the synchronized select reads inactive (high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_i | input | 1 | Role: 1 master, 0 slave |
| fault_en_i | input | 1 | Allows the fault flag to set |
| err_ie_i | input | 1 | Error interrupt enable |
| spi_en_i | input | 1 | Port enable bit |
| ss_n_i | input | 1 | Raw slave-select pin, active low |
| xfer_active_i | input | 1 | Transfer in progress, from the shift engine |
| stat_rd_i | input | 1 | CPU status register read strobe |
| ctrl_wr_i | input | 1 | CPU control register write strobe |
| fault_o | output | 1 | Sticky mode-fault flag |
| irq_o | output | 1 | Error interrupt request |
| en_clr_o | output | 1 | Request to clear the port enable |
| tx_empty_set_o | output | 1 | Request to set transmit-empty |
| cnt_rst_o | output | 1 | Request to reset the bit counter |
| sck_oe_o | output | 1 | Serial clock pin drive enable |
| mosi_oe_o | output | 1 | Master-out data pin drive enable |
| miso_oe_o | output | 1 | Master-in data pin drive enable |

## Verification
- **Master-role patterns:** a steady low select shows the three-edge synchronizer delay and the one-time teardown.
- **Slave-role patterns:** these separate a bare high level from a rising edge, and a rise with no transfer from a rise during a transfer.
- **Clearing-handshake patterns:** the handshake is tried without the status read, with it, and with the condition still present at the write. These tell a correct clear apart from an early or lost one.
- **Random phase:** seeded random role, select, strobe and enable activity is compared against a cycle model each cycle. This catches ordering effects between simultaneous reads, writes and fault events.

// File: rtl/spi_modefault_det.sv
module spi_modefault_det (
  input  logic clk,
  input  logic rst_n,
  input  logic master_i,
  input  logic fault_en_i,
  input  logic err_ie_i,
  input  logic spi_en_i,
  input  logic ss_n_i,
  input  logic xfer_active_i,
  input  logic stat_rd_i,
  input  logic ctrl_wr_i,
  output logic fault_o,
  output logic irq_o,
  output logic en_clr_o,
  output logic tx_empty_set_o,
  output logic cnt_rst_o,
  output logic sck_oe_o,
  output logic mosi_oe_o,
  output logic miso_oe_o
);

  logic ss_meta, ss_sync, ss_last;
  logic flag_q, armed_q, tear_q;
  logic hit_master, hit_slave, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_meta <= 1'b1;
      ss_sync <= 1'b1;
      ss_last <= 1'b1;
    end else begin
      ss_meta <= ss_n_i;
      ss_sync <= ss_meta;
      ss_last <= ss_sync;
    end
  end

  assign hit_master = master_i & fault_en_i & spi_en_i & ~ss_sync;
  assign hit_slave  = ~master_i & fault_en_i & spi_en_i & xfer_active_i & ss_sync & ~ss_last;
  assign hit        = hit_master | hit_slave;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      tear_q  <= 1'b0;
    end else begin
      tear_q <= hit_master;
      if (hit)
        flag_q <= 1'b1;
      else if (ctrl_wr_i && armed_q)
        flag_q <= 1'b0;
      if (ctrl_wr_i)
        armed_q <= 1'b0;
      else if (stat_rd_i && flag_q)
        armed_q <= 1'b1;
    end
  end

  assign fault_o        = flag_q;
  assign irq_o          = flag_q & err_ie_i;
  assign en_clr_o       = tear_q;
  assign tx_empty_set_o = tear_q;
  assign cnt_rst_o      = tear_q;
  assign sck_oe_o       = spi_en_i & master_i & ~tear_q;
  assign mosi_oe_o      = spi_en_i & master_i & ~tear_q;
  assign miso_oe_o      = spi_en_i & ~master_i;

endmodule

module spi_modefault_det_chk (
  input logic clk,
  input logic rst_n,
  input logic master_i,
  input logic fault_en_i,
  input logic err_ie_i,
  input logic ctrl_wr_i,
  input logic fault_o,
  input logic irq_o,
  input logic en_clr_o,
  input logic sck_oe_o,
  input logic mosi_oe_o,
  input logic miso_oe_o
);
  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  AST_TEAR_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n) en_clr_o |-> fault_o); // R8
  AST_SLAVE_NO_TEAR: assert property (@(posedge clk) disable iff (!rst_n) (live && !$past(master_i)) |-> !en_clr_o); // R8
  AST_TEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) en_clr_o |-> (!sck_oe_o && !mosi_oe_o)); // R9
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n) !(miso_oe_o && (sck_oe_o || mosi_oe_o))); // R9
  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) (live && !$past(fault_en_i) && !$past(fault_o)) |-> !fault_o); // R4
  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (live && $past(fault_o) && !fault_o) |-> $past(ctrl_wr_i)); // R5
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> (fault_o && err_ie_i)); // R7
endmodule

bind spi_modefault_det spi_modefault_det_chk u_chk (
  .clk(clk), .rst_n(rst_n), .master_i(master_i), .fault_en_i(fault_en_i),
  .err_ie_i(err_ie_i), .ctrl_wr_i(ctrl_wr_i), .fault_o(fault_o), .irq_o(irq_o),
  .en_clr_o(en_clr_o), .sck_oe_o(sck_oe_o), .mosi_oe_o(mosi_oe_o), .miso_oe_o(miso_oe_o)
);

// File: tb/tb_spi_modefault_det.sv
module tb_spi_modefault_det;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic master_i = 1'b1, fault_en_i = 1'b1, err_ie_i = 1'b0, spi_en_i = 1'b0;
  logic ss_n_i = 1'b1, xfer_active_i = 1'b0, stat_rd_i = 1'b0, ctrl_wr_i = 1'b0;
  logic fault_o, irq_o, en_clr_o, tx_empty_set_o, cnt_rst_o, sck_oe_o, mosi_oe_o, miso_oe_o;
  int checks = 0, errors = 0;
  bit auto_clr = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  spi_modefault_det dut (.*);

  logic m_s1, m_s2, m_prev, m_fault, m_arm, m_tear;
  logic m_cm, m_cs;
  assign m_cm = master_i & fault_en_i & spi_en_i & ~m_s2;
  assign m_cs = ~master_i & fault_en_i & spi_en_i & xfer_active_i & m_s2 & ~m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_prev <= 1'b1;
      m_fault <= 1'b0; m_arm <= 1'b0; m_tear <= 1'b0;
    end else begin
      m_s1 <= ss_n_i; m_s2 <= m_s1; m_prev <= m_s2;
      m_tear <= m_cm;
      if (m_cm | m_cs) m_fault <= 1'b1;
      else if (ctrl_wr_i & m_arm) m_fault <= 1'b0;
      if (ctrl_wr_i) m_arm <= 1'b0;
      else if (stat_rd_i & m_fault) m_arm <= 1'b1;
    end
  end

  function automatic logic exp_irq();
    return m_fault & err_ie_i;
  endfunction
  function automatic logic exp_mst_oe();
    return spi_en_i & master_i & ~m_tear;
  endfunction
  function automatic logic exp_miso_oe();
    return spi_en_i & ~master_i;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R3 fault_o vs model", fault_o, m_fault);
    chk("R7 irq_o vs model", irq_o, exp_irq());
    chk("R8 en_clr_o vs model", en_clr_o, m_tear);
    chk("R8 tx_empty_set_o vs model", tx_empty_set_o, m_tear);
    chk("R8 cnt_rst_o vs model", cnt_rst_o, m_tear);
    chk("R9 sck_oe_o vs model", sck_oe_o, exp_mst_oe());
    chk("R9 mosi_oe_o vs model", mosi_oe_o, exp_mst_oe());
    chk("R9 miso_oe_o vs model", miso_oe_o, exp_miso_oe());
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      cmp_model();
      stat_rd_i = 1'b0;
      ctrl_wr_i = 1'b0;
      if (auto_clr && en_clr_o) spi_en_i = 1'b0;
    end
  endtask

  task automatic clear_flag();
    stat_rd_i = 1'b1; step();
    ctrl_wr_i = 1'b1; step();
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R10 reset fault_o", fault_o, 1'b0);
    chk("R10 reset irq_o", irq_o, 1'b0);
    chk("R10 reset en_clr_o", en_clr_o, 1'b0);
    rst_n = 1'b1;
    // Master role, select low from the first cycles: R10 sync reset means no fault yet
    ss_n_i = 1'b0; spi_en_i = 1'b1; master_i = 1'b1; err_ie_i = 1'b1;
    step();
    chk("R10 sync starts inactive", fault_o, 1'b0);
    step();
    chk("R1 no fault after two edges", fault_o, 1'b0);
    chk("R9 master drives sck", sck_oe_o, 1'b1);
    chk("R9 master does not drive miso", miso_oe_o, 1'b0);
    step();
    chk("R2 master low select sets fault", fault_o, 1'b1);
    chk("R1 fault on third edge", fault_o, 1'b1);
    chk("R8 teardown pulse", cnt_rst_o, 1'b1);
    chk("R9 pins released on teardown", mosi_oe_o, 1'b0);
    chk("R7 irq with enable", irq_o, 1'b1);
    step();
    chk("R8 teardown stops after enable cleared", en_clr_o, 1'b0);
    err_ie_i = 1'b0; step();
    chk("R7 irq masked", irq_o, 1'b0);
    ss_n_i = 1'b1; step(3);
    ctrl_wr_i = 1'b1; step();
    chk("R5 write without read keeps flag", fault_o, 1'b1);
    clear_flag();
    chk("R5 read then write clears flag", fault_o, 1'b0);
    // R6: condition present during the clearing write
    auto_clr = 1'b0; spi_en_i = 1'b1; ss_n_i = 1'b0; step(3);
    chk("R2 fault set again", fault_o, 1'b1);
    clear_flag();
    chk("R6 flag held while condition present", fault_o, 1'b1);
    ss_n_i = 1'b1; step(3);
    clear_flag();
    chk("R6 flag clears once condition gone", fault_o, 1'b0);
    // Slave role
    master_i = 1'b0; ss_n_i = 1'b0; step(4);
    chk("R9 slave drives miso", miso_oe_o, 1'b1);
    chk("R9 slave does not drive sck", sck_oe_o, 1'b0);
    chk("R3 slave low select no fault", fault_o, 1'b0);
    ss_n_i = 1'b1; step(4);
    chk("R3 rise without transfer no fault", fault_o, 1'b0);
    ss_n_i = 1'b0; step(3);
    xfer_active_i = 1'b1; ss_n_i = 1'b1; step(2);
    chk("R1 slave rise not yet seen", fault_o, 1'b0);
    step();
    chk("R3 rise during transfer sets fault", fault_o, 1'b1);
    chk("R8 no teardown in slave", en_clr_o, 1'b0);
    step(3);
    chk("R3 high level alone keeps state", fault_o, 1'b1);
    fault_en_i = 1'b0; step();
    chk("R4 disable keeps set flag", fault_o, 1'b1);
    clear_flag();
    master_i = 1'b1; ss_n_i = 1'b0; xfer_active_i = 1'b0; step(5);
    chk("R4 no set while disabled", fault_o, 1'b0);
    fault_en_i = 1'b1; ss_n_i = 1'b1; auto_clr = 1'b1; step(3);
    // Random phase
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 40) == 0) master_i = ~master_i;
      if ($urandom_range(0, 7) == 0) ss_n_i = ~ss_n_i;
      if ($urandom_range(0, 3) == 0) xfer_active_i = $urandom_range(0, 1);
      if ($urandom_range(0, 30) == 0) fault_en_i = ~fault_en_i;
      if ($urandom_range(0, 10) == 0) err_ie_i = ~err_ie_i;
      if (!spi_en_i && $urandom_range(0, 9) == 0) spi_en_i = 1'b1;
      stat_rd_i = ($urandom_range(0, 5) == 0);
      ctrl_wr_i = ($urandom_range(0, 5) == 0);
      step();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule